// File: doc/BRIEF.md
# Stream Buffer with Registered Output Slot

This block sits between a stream producer and a stream consumer that both speak AXI4-Stream. Each beat the sink port accepts is written, with its end-of-packet flag beside the payload, into a single-clock ring of storage. The storage is read through a register, so a word pulled from it shows up one clock later.

That register is also the output slot. It drives the source port directly, and the storage is popped only when the slot will be empty after the coming edge. The consumer can therefore stall at any time without seeing valid drop, the payload change, or a beat lost or repeated. The producer sees ready fall only when the storage ring itself is full. Including the output slot, the block holds DEPTH+1 beats.

Top module: `axis_skid_fifo`

## Requirements
- R1: While reset (active-low `rst_n`, sampled on the rising edge) is applied, and on the first cycle after it, `m_axis_tvalid` is low and `s_axis_tready` is high.
- R2: `s_axis_tready` is low exactly when the storage ring holds DEPTH words. The block then holds DEPTH+1 beats in total, counting the output slot. A beat is taken only in a cycle where both `s_axis_tvalid` and `s_axis_tready` are high.
- R3: Beats leave the source port in the order they were taken at the sink port, and each keeps its own `tlast` value alongside its `tdata`.
- R4: Once `m_axis_tvalid` is high, it stays high until a cycle in which `m_axis_tready` is also high.
- R5: While `m_axis_tvalid` is high and `m_axis_tready` is low, `m_axis_tdata` and `m_axis_tlast` keep their values into the next cycle.
- R6: Under any pattern of consumer stalls, every taken beat is delivered exactly once. `m_axis_tvalid` is never high while no taken beat remains undelivered.
- R7: When the block is empty, a beat taken at clock edge N raises `m_axis_tvalid` after edge N+1.
- R8: When the consumer accepts a beat in the same cycle that the next stored word is popped, that word replaces it in the output slot with no idle cycle. With both sides always ready, a burst of K beats leaves in K consecutive cycles.
- R9: Values on `s_axis_tdata` and `s_axis_tlast` while `s_axis_tvalid` is low are not stored and never appear on the source port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_axis_tvalid | input | 1 | Sink beat valid |
| s_axis_tready | output | 1 | Sink ready: storage ring has room |
| s_axis_tdata | input | DATA_W | Sink payload |
| s_axis_tlast | input | 1 | Sink end-of-packet flag |
| m_axis_tvalid | output | 1 | Source beat valid |
| m_axis_tready | input | 1 | Consumer ready |
| m_axis_tdata | output | DATA_W | Source payload |
| m_axis_tlast | output | 1 | Source end-of-packet flag |

## Verification
The bench fills the block with the consumer stalled and counts how many beats are accepted before ready falls. An off-by-one in the full test would show up as DEPTH or DEPTH+2 instead of DEPTH+1. It then runs a long random burst against random stalls. A design that pops while the slot is held overwrites an unsent beat and fails the ordering compare. A design that keeps stale valid delivers a beat twice, which the scoreboard sees as a beat with nothing queued. The bench also measures first-beat latency and back-to-back throughput, where a one-cycle gap between beats exposes a missing same-cycle reload. Finally, it toggles the payload pins while valid is low to confirm that nothing leaks into the stream.

// File: rtl/axis_skid_fifo.sv
module axis_skid_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_axis_tvalid,
  output logic              s_axis_tready,
  input  logic [DATA_W-1:0] s_axis_tdata,
  input  logic              s_axis_tlast,
  output logic              m_axis_tvalid,
  input  logic              m_axis_tready,
  output logic [DATA_W-1:0] m_axis_tdata,
  output logic              m_axis_tlast
);
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int WW = DATA_W + 1;

  logic [WW-1:0] ring [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr;
  logic [WW-1:0] slot_word;
  logic          slot_vld;

  wire [AW:0] fill  = wr_ptr - rd_ptr;
  wire        full  = fill[AW];
  wire        empty = (fill == '0);
  wire        push  = s_axis_tvalid & ~full;
  wire        pop   = ~empty & (~slot_vld | m_axis_tready);

  assign s_axis_tready = ~full;
  assign m_axis_tvalid = slot_vld;
  assign {m_axis_tlast, m_axis_tdata} = slot_word;

  always_ff @(posedge clk)
    if (push) ring[wr_ptr[AW-1:0]] <= {s_axis_tlast, s_axis_tdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (pop) slot_word <= ring[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n)             slot_vld <= 1'b0;
    else if (pop)           slot_vld <= 1'b1;
    else if (m_axis_tready) slot_vld <= 1'b0;
  end
endmodule

// File: rtl/axis_skid_fifo_chk.sv
module axis_skid_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_axis_tvalid,
  input logic              s_axis_tready,
  input logic [DATA_W-1:0] s_axis_tdata,
  input logic              s_axis_tlast,
  input logic              m_axis_tvalid,
  input logic              m_axis_tready,
  input logic [DATA_W-1:0] m_axis_tdata,
  input logic              m_axis_tlast
);
  localparam int OW = $clog2(DEPTH + 2) + 1;

  logic [OW-1:0] held;
  wire in_hs  = s_axis_tvalid & s_axis_tready;
  wire out_hs = m_axis_tvalid & m_axis_tready;

  always_ff @(posedge clk) begin
    if (!rst_n) held <= '0;
    else        held <= held + OW'(in_hs) - OW'(out_hs);
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!m_axis_tvalid && s_axis_tready));

  p_ready_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !s_axis_tready |-> (held == OW'(DEPTH + 1)));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    held <= OW'(DEPTH + 1));

  p_valid_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_axis_tvalid && !m_axis_tready) |=> m_axis_tvalid);

  p_payload_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_axis_tvalid && !m_axis_tready) |=> ($stable(m_axis_tdata) && $stable(m_axis_tlast)));

  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_axis_tvalid |-> (held != '0));
endmodule

bind axis_skid_fifo axis_skid_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .s_axis_tvalid(s_axis_tvalid), .s_axis_tready(s_axis_tready),
  .s_axis_tdata(s_axis_tdata), .s_axis_tlast(s_axis_tlast),
  .m_axis_tvalid(m_axis_tvalid), .m_axis_tready(m_axis_tready),
  .m_axis_tdata(m_axis_tdata), .m_axis_tlast(m_axis_tlast)
);

// File: tb/axis_skid_fifo_tb.sv
`timescale 1ns/1ps
module axis_skid_fifo_tb;
  localparam int DW = 8;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_ready, s_last = 0;
  logic [DW-1:0] s_data = '0;
  logic m_valid, m_ready, m_last;
  logic [DW-1:0] m_data;

  axis_skid_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_axis_tvalid(s_valid), .s_axis_tready(s_ready),
    .s_axis_tdata(s_data), .s_axis_tlast(s_last),
    .m_axis_tvalid(m_valid), .m_axis_tready(m_ready),
    .m_axis_tdata(m_data), .m_axis_tlast(m_last));

  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, hs_count = 0, first_hs = 0, last_hs = 0;
  bit mark_first = 0, stall_prev = 0;
  int rmode = 1;
  logic [DW:0] q[$];
  logic [DW:0] prev_word;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    case (rmode)
      0: m_ready = 1'b0;
      1: m_ready = 1'b1;
      default: m_ready = $urandom_range(0, 1);
    endcase
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (stall_prev) begin
        check(m_valid, "R4", "valid dropped while stalled", int'(m_valid), 1);
        check({m_last, m_data} == prev_word, "R5", "payload moved while stalled",
              int'({m_last, m_data}), int'(prev_word));
      end
      if (m_valid && m_ready) begin
        if (q.size() == 0) check(0, "R6", "beat with nothing queued", int'({m_last, m_data}), -1);
        else begin
          logic [DW:0] e;
          e = q.pop_front();
          check({m_last, m_data} == e, "R3", "beat order/last", int'({m_last, m_data}), int'(e));
        end
        hs_count++;
        last_hs = cyc;
        if (mark_first) begin first_hs = cyc; mark_first = 0; end
      end
      stall_prev = m_valid && !m_ready;
      prev_word = {m_last, m_data};
    end else stall_prev = 0;
  end

  task automatic send(logic [DW:0] w);
    s_valid = 1'b1;
    {s_last, s_data} = w;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    q.push_back(w);
    @(posedge clk); #1;
    s_valid = 1'b0;
    s_data = DW'($urandom);
    s_last = 1'($urandom);
  endtask

  task automatic drain();
    rmode = 1;
    repeat (DEPTH + 6) @(posedge clk);
    #1;
    check(q.size() == 0, "R6", "beats left undelivered", q.size(), 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int acc, h0;
    m_ready = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!m_valid, "R1", "valid after reset", int'(m_valid), 0);
    check(s_ready, "R1", "ready after reset", int'(s_ready), 1);

    // R7 latency from empty
    @(posedge clk); #1;
    s_valid = 1; {s_last, s_data} = 9'h1A5;
    @(negedge clk);
    check(s_ready, "R7", "ready when empty", int'(s_ready), 1);
    q.push_back(9'h1A5);
    @(posedge clk); #1 s_valid = 0;
    @(negedge clk);
    check(!m_valid, "R7", "valid one edge after take", int'(m_valid), 0);
    @(negedge clk);
    check(m_valid, "R7", "valid two edges after take", int'(m_valid), 1);
    drain();

    // R2 capacity with consumer stalled
    rmode = 0;
    @(posedge clk); #1;
    acc = 0;
    s_valid = 1;
    forever begin
      {s_last, s_data} = {1'(acc & 1), DW'(8'h40 + acc)};
      @(negedge clk);
      if (!s_ready) break;
      q.push_back({s_last, s_data});
      acc++;
      @(posedge clk); #1;
    end
    check(acc == DEPTH + 1, "R2", "beats taken before ready fell", acc, DEPTH + 1);
    repeat (3) @(negedge clk);
    check(!s_ready, "R2", "ready stays low while full", int'(s_ready), 0);
    check(m_valid, "R4", "valid held while full", int'(m_valid), 1);
    @(posedge clk); #1 s_valid = 0;
    drain();

    // R9 idle payload ignored
    h0 = hs_count;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1 s_data = DW'($urandom); s_last = 1'($urandom);
      @(negedge clk);
      check(!m_valid, "R9", "output while sink idle", int'(m_valid), 0);
    end
    check(hs_count == h0, "R9", "beats delivered from idle sink", hs_count - h0, 0);

    // R8 back-to-back throughput
    @(posedge clk); #1;
    mark_first = 1;
    h0 = hs_count;
    for (int i = 0; i < 20; i++) send({1'(i == 19), DW'(i * 7 + 3)});
    drain();
    check(hs_count - h0 == 20, "R8", "burst beat count", hs_count - h0, 20);
    check(last_hs - first_hs == 19, "R8", "burst span in cycles", last_hs - first_hs, 19);

    // R3/R6 random stalls and gaps
    rmode = 2;
    @(posedge clk); #1;
    for (int i = 0; i < 300; i++) begin
      int gap = $urandom_range(0, 2);
      repeat (gap) begin @(posedge clk); #1 s_data = DW'($urandom); end
      send({1'($urandom), DW'($urandom)});
    end
    drain();

    // R6 stall-heavy burst
    rmode = 0;
    for (int i = 0; i < 5; i++) send({1'b0, DW'(200 + i)});
    rmode = 2;
    for (int i = 0; i < 40; i++) send({1'(i % 4 == 3), DW'(i)});
    drain();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule